// File: doc/BRIEF.md
# DAC Serial Write Frame Controller

This block sits between a three-wire serial host link and the digital side of a voltage-output DAC core. The host lowers an active-low frame select, then clocks in a 16-bit word, most significant bit first. The word arrives on a data line and is sampled on falling edges of a serial clock. After exactly sixteen such edges, with select still low, the block decodes the word into a power-down mode and a DAC code. It then presents both on registered outputs together with a one-cycle update strobe.

All three serial inputs are brought into a faster system clock through two-flop synchronisers, and edges are detected in that domain. A frame that is cut short by select rising is dropped, and the outputs keep their old values. A synchronous reset, standing in for power-on and brownout detection, forces a zero code and normal mode. That state is held until the first complete frame arrives. The code width is a parameter: 8, 10 or 12 bits.

Top module: `dac_frame_rx`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, code_out is 0, pd_out is 0 and upd_out is 0.
- R2: After reset, code_out stays 0 and upd_out stays low until a complete 16-edge frame has been received.
- R3: A frame of 16 serial-clock falling edges, captured MSB first while sel_n is low, loads code_out with word bits [13:14-DATA_W]; word bits below that are don't-care.
- R4: Each accepted frame gives exactly one upd_out pulse, one system clock long, in the same cycle as the new code_out and pd_out values appear.
- R5: When select rises before the 16th falling edge, the frame is discarded: no upd_out pulse is produced and code_out and pd_out keep their previous values.
- R6: Serial-clock falling edges after the 16th are ignored until select rises and falls again; the first 16 bits alone decide the result.
- R7: Serial-clock edges while select is high shift nothing and do not disturb the next frame.
- R8: If the select rise and the 16th falling edge reach the synchronised domain in the same system cycle, the frame counts as aborted.
- R9: Word bits [15:14] load pd_out with the mode: 00 normal, 01 pull-down through 1 kOhm, 10 pull-down through 100 kOhm, 11 high impedance.
- R10: Reset in the middle of a frame discards the partial frame; edges that follow without a new select falling edge are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset (power-on / brownout stand-in) |
| sel_n_in | input | 1 | Active-low frame select, asynchronous |
| sck_in | input | 1 | Serial clock, data captured on its falling edge, asynchronous |
| sdi_in | input | 1 | Serial data, MSB first, asynchronous |
| code_out | output | DATA_W | Registered DAC code |
| pd_out | output | 2 | Registered power-down mode |
| upd_out | output | 1 | One-cycle strobe marking new code_out / pd_out |

## Verification
Two events can coincide: the 16th serial-clock falling edge that would complete a frame, and the select rise that aborts it. The bench drives the last clock fall and the select rise in the same time step. Both then pass through identical synchronisers and land in the same system cycle. The run is judged correct only if no update strobe appears and code_out and pd_out hold the values of the previous accepted frame.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  localparam int FRAME_BITS = 16;
  localparam int MODE_MSB   = FRAME_BITS - 1;
  localparam int CODE_MSB   = FRAME_BITS - 3;

  typedef enum logic [1:0] {
    PD_NORMAL    = 2'b00,
    PD_PULL_LOW  = 2'b01,
    PD_PULL_WEAK = 2'b10,
    PD_HIZ       = 2'b11
  } pd_mode_e;
endpackage

// File: rtl/dfr_sync.sv
module dfr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dfr_shifter.sv
module dfr_shifter
  import dfr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sel_n_s,
  input  logic                  sck_s,
  input  logic                  sdi_s,
  output logic                  frame_done,
  output logic [FRAME_BITS-1:0] frame_word
);
  localparam int CNT_W = $clog2(FRAME_BITS);

  logic             sel_q, sck_q, armed;
  logic [CNT_W-1:0] cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic sck_fall, sel_fall, take;

  assign sck_fall   = sck_q & ~sck_s;
  assign sel_fall   = sel_q & ~sel_n_s;
  assign take       = sck_fall & armed & ~sel_n_s;
  assign frame_done = take && (cnt == CNT_W'(FRAME_BITS-1));
  assign frame_word = {shreg[FRAME_BITS-2:0], sdi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      sck_q <= 1'b0;
      armed <= 1'b0;
      cnt   <= '0;
      shreg <= '0;
    end else begin
      sel_q <= sel_n_s;
      sck_q <= sck_s;
      if (sel_n_s) begin
        armed <= 1'b0;
      end else if (sel_fall) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (take) begin
        shreg <= frame_word;
        cnt   <= cnt + 1'b1;
        if (frame_done) armed <= 1'b0;
      end
    end
  end

  AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !armed); // R6
  AST_SELECT_HIGH_IDLE: assert property (@(posedge clk) disable iff (rst)
    sel_n_s |=> !armed); // R7
endmodule

// File: rtl/dfr_commit.sv
module dfr_commit
  import dfr_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_done,
  input  logic [FRAME_BITS-1:0] frame_word,
  output logic [DATA_W-1:0]     code,
  output pd_mode_e              pd,
  output logic                  upd
);
  localparam int CODE_LSB = CODE_MSB - DATA_W + 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= '0;
      pd   <= PD_NORMAL;
      upd  <= 1'b0;
    end else begin
      upd <= frame_done;
      if (frame_done) begin
        code <= frame_word[CODE_MSB:CODE_LSB];
        pd   <= pd_mode_e'(frame_word[MODE_MSB:MODE_MSB-1]);
      end
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    upd |=> !upd); // R4
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
    !upd |-> ($stable(code) && $stable(pd))); // R5
endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
  import dfr_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n_in,
  input  logic              sck_in,
  input  logic              sdi_in,
  output logic [DATA_W-1:0] code_out,
  output logic [1:0]        pd_out,
  output logic              upd_out
);
  logic [2:0]            raw_bus, sync_bus;
  logic                  frame_done;
  logic [FRAME_BITS-1:0] frame_word;
  pd_mode_e              pd_mode;

  assign raw_bus = {sel_n_in, sck_in, sdi_in};

  dfr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_bus), .q(sync_bus)
  );

  dfr_shifter u_shift (
    .clk(clk), .rst(rst),
    .sel_n_s(sync_bus[2]), .sck_s(sync_bus[1]), .sdi_s(sync_bus[0]),
    .frame_done(frame_done), .frame_word(frame_word)
  );

  dfr_commit #(.DATA_W(DATA_W)) u_commit (
    .clk(clk), .rst(rst),
    .frame_done(frame_done), .frame_word(frame_word),
    .code(code_out), .pd(pd_mode), .upd(upd_out)
  );

  assign pd_out = pd_mode;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (code_out == '0 && pd_out == 2'b00 && !upd_out)); // R1
endmodule

// File: tb/dac_frame_rx_tb.sv
module dac_frame_rx_tb;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst, sel_n, sck, sdi;
  logic [DW-1:0] code_out;
  logic [1:0]    pd_out;
  logic          upd_out;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;
  logic [DW+1:0] expq[$];
  logic [DW-1:0] last_code = '0;
  logic [1:0]    last_pd = 2'b00;
  logic          upd_prev = 1'b0;

  always #4 clk = ~clk;

  dac_frame_rx #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .sel_n_in(sel_n), .sck_in(sck), .sdi_in(sdi),
    .code_out(code_out), .pd_out(pd_out), .upd_out(upd_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bits(input logic [15:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      sdi = w[15 - (i % 16)];
      sck = 1'b1; clks(4);
      sck = 1'b0; clks(4);
    end
  endtask

  task automatic send(input logic [15:0] w, input int n);
    if (n >= 16) begin
      expq.push_back({w[15:14], w[13 -: DW]});
      last_pd   = w[15:14];
      last_code = w[13 -: DW];
    end
    sel_n = 1'b0; clks(4);
    bits(w, n);
    clks(2);
    sel_n = 1'b1; clks(10);
  endtask

  task automatic check_hold(input string req);
    check(code_out == last_code, req, code_out, last_code);
    check(pd_out == last_pd, req, pd_out, last_pd);
  endtask

  // scoreboard monitor: R3 R4 R9
  always @(negedge clk) begin
    if (!rst) begin
      if (upd_prev && upd_out) check(1'b0, "R4 strobe wider than one cycle", 1, 0);
      if (upd_out) begin
        if (expq.size() == 0) begin
          check(1'b0, "R4/R5 unexpected update", int'(code_out), 0);
        end else begin
          logic [DW+1:0] e;
          e = expq.pop_front();
          check(code_out == e[DW-1:0], "R3 code", code_out, e[DW-1:0]);
          check(pd_out == e[DW+1:DW], "R9 mode", pd_out, e[DW+1:DW]);
        end
      end
    end
    upd_prev = upd_out;
  end

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst = 1'b1; sel_n = 1'b1; sck = 1'b0; sdi = 1'b0;
    clks(4);
    check(code_out == '0 && pd_out == 2'b00 && !upd_out, "R1 reset", code_out, 0);
    rst = 1'b0; clks(1);
    check(code_out == '0 && !upd_out, "R1 after reset", code_out, 0);

    send(16'hFFFF, 10);
    check(code_out == '0, "R2 zero before first frame", code_out, 0);

    send(16'h1A5C, 16);                       // R3 normal mode
    check_hold("R3 direct");
    send(16'h4FF3, 16);                       // R9 01
    send(16'h8001, 16);                       // R9 10 (code 0)
    send(16'hC7FC, 16);                       // R9 11
    check_hold("R9 direct");

    send(16'h3FFC, 15);                       // R5 abort after 15 edges
    check_hold("R5 abort");

    send(16'h2468, 20);                       // R6 extra edges
    check_hold("R6 extra edges");

    sdi = 1'b1;                               // R7 clocks with select high
    for (int i = 0; i < 5; i++) begin
      sck = 1'b1; clks(4); sck = 1'b0; clks(4);
    end
    check_hold("R7 idle clocks");
    send(16'h8010, 16);
    check_hold("R7 next frame");

    begin                                     // R8 coincident abort and 16th edge
      logic [15:0] w;
      w = 16'h5AA4;
      sel_n = 1'b0; clks(4);
      bits(w, 15);
      sdi = w[0];
      sck = 1'b1; clks(4);
      sck = 1'b0; sel_n = 1'b1;
      clks(12);
    end
    check_hold("R8 coincident");

    sel_n = 1'b0; clks(4);                    // R10 reset mid frame
    bits(16'hFFFC, 8);
    rst = 1'b1; clks(2); rst = 1'b0;
    bits(16'hFFFC, 8);
    clks(2); sel_n = 1'b1; clks(10);
    last_code = '0; last_pd = 2'b00;
    check_hold("R10 reset mid frame");
    send(16'hC3FC, 16);
    check_hold("R10 recovery");

    clks(4);
    check(expq.size() == 0, "R4 all frames strobed", expq.size(), 0);
    finish_run();
  end
endmodule